// File: doc/BRIEF.md
# Staged Expiry Watchdog

This block supervises software liveness by counting expiry pulses from one of several free-running timers and escalating as they accumulate. Each group of expiries (the group size is a programmable period count) advances a stage counter. The first stage raises a local interrupt, stages two to four raise a fast interrupt and a remote interrupt, and the fifth stage raises the reset requests. Software keeps the system alive by issuing a start command before the fifth stage. A start command rearms the counter.

Three registers sit on a simple 32-bit write/read bus: a configuration word, a command word and a key word. Stopping the watchdog is guarded: a disable command only takes effect right after the key word has been written. Once the local interrupt enable is set, the configuration freezes until the next hardware reset. Reset requests are sticky and remain asserted until that reset.

Top module: `stage_wdog`

## Requirements
- R1: After reset all five outputs are low, the watchdog is stopped and the configuration word reads back as 0.
- R2: A write to offset 0x0 stores the configuration: bits 3:0 timer source, bits 11:4 period count, bit 12 local interrupt enable, bit 13 fast interrupt enable, bit 14 remote interrupt enable, bit 15 debug reset enable, bit 16 power-on reset enable. A read of offset 0x0 returns it on rd_data one cycle later. A read of any other offset returns 0.
- R3: While the stored local interrupt enable (bit 12) is 1, writes to offset 0x0 leave the configuration unchanged.
- R4: Writing bit 0 of offset 0x8 (start) makes the watchdog run, clears the group and stage counters and drops the three interrupt outputs. An asserted reset output stays high.
- R5: Only a pulse on exp_i[source] counts, and only while the watchdog runs. A source value of N_TMR or above never counts. A stage completes after `period` counted pulses, and a period of 0 acts as 1.
- R6: Completing stage 1 raises irq_local_o if enabled. Completing stage 2, 3 or 4 raises irq_fast_o and irq_remote_o where enabled. Interrupts stay high until a start or an effective disable.
- R7: Completing stage 5 raises rst_debug_o and rst_por_o where enabled. These stay high until hardware reset. Further groups do not advance the stage past 5.
- R8: Writing 0x0000C45A to offset 0xC arms the key. Any other value written there disarms it, and any write to offset 0x8 consumes it. A disable command (bit 1 of offset 0x8) without an armed key is ignored.
- R9: An effective disable stops counting and drops the three interrupt outputs. When bits 0 and 1 are written together with the key armed, the disable wins.
- R10: An output change appears on the clock edge that samples the pulse completing the stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | DATA_W | Read data, registered |
| exp_i | input | N_TMR | Timer expiry pulses, one per timer |
| irq_local_o | output | 1 | Local interrupt (stage 1) |
| irq_fast_o | output | 1 | Fast interrupt (stages 2 to 4) |
| irq_remote_o | output | 1 | Remote interrupt (stages 2 to 4) |
| rst_debug_o | output | 1 | Debug reset request (stage 5) |
| rst_por_o | output | 1 | Power-on reset request (stage 5) |

## Verification
The bench builds the block with N_TMR = 6 while the source field keeps its four bits. Source values 6 to 15 can therefore be programmed, which exercises the case where no timer is selected and no pulse counts. The period field keeps its full width, so periods of 0, 1 and 3 are used. These cover the 0-as-1 rule and grouping with a remainder.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // configuration word, bit 0 at the bottom
  typedef struct packed {
    logic       por_en;   // 16
    logic       dbg_en;   // 15
    logic       rmt_en;   // 14
    logic       fast_en;  // 13
    logic       loc_en;   // 12, also freezes the word
    logic [7:0] period;   // 11:4
    logic [3:0] src;      // 3:0
  } wd_cfg_t;

  localparam int CFG_W   = $bits(wd_cfg_t);
  localparam int SRC_W   = 4;
  localparam int PER_W   = 8;
  localparam int STG_W   = 3;

  localparam logic [3:0] OFS_CFG = 4'h0;
  localparam logic [3:0] OFS_CMD = 4'h8;
  localparam logic [3:0] OFS_KEY = 4'hC;

  localparam logic [31:0] KEY_WORD = 32'h0000_C45A;

  localparam int CMD_GO   = 0;
  localparam int CMD_HALT = 1;

  localparam int LAST_STAGE = 5;

endpackage

// File: rtl/wdog_regif.sv
module wdog_regif
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output wd_cfg_t           cfg_o,
  output logic              locked_o,
  output logic              armed_o,
  output logic              go_o,
  output logic              halt_o
);

  logic cfg_hit, cmd_hit, key_hit, rd_cfg;

  assign cfg_hit = wr_en && (wr_addr == ADDR_W'(OFS_CFG));
  assign cmd_hit = wr_en && (wr_addr == ADDR_W'(OFS_CMD));
  assign key_hit = wr_en && (wr_addr == ADDR_W'(OFS_KEY));
  assign rd_cfg  = rd_en && (rd_addr == ADDR_W'(OFS_CFG));

  assign locked_o = cfg_o.loc_en;

  // configuration word, frozen once the local interrupt is enabled
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_o <= '0;
    end else if (cfg_hit && !cfg_o.loc_en) begin
      cfg_o <= wd_cfg_t'(wr_data[CFG_W-1:0]);
    end
  end

  // one-shot key: armed by the exact word, spent by any command
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_o <= 1'b0;
    end else if (key_hit) begin
      armed_o <= (wr_data == DATA_W'(KEY_WORD));
    end else if (cmd_hit) begin
      armed_o <= 1'b0;
    end
  end

  assign halt_o = cmd_hit && wr_data[CMD_HALT] && armed_o;
  assign go_o   = cmd_hit && wr_data[CMD_GO] && !halt_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= rd_cfg ? DATA_W'(cfg_o) : '0;
    end
  end

endmodule

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel
  import wdog_pkg::*;
#(
  parameter int N_TMR = 16
) (
  input  logic [N_TMR-1:0] exp_i,
  input  logic [SRC_W-1:0] sel_i,
  output logic             tick_o
);

  logic [N_TMR-1:0] hit;

  // timers past the field range can never be picked
  for (genvar i = 0; i < N_TMR; i++) begin : g_lane
    if (i < (1 << SRC_W)) begin : g_reach
      assign hit[i] = exp_i[i] && (sel_i == SRC_W'(i));
    end else begin : g_unreach
      assign hit[i] = 1'b0;
    end
  end

  assign tick_o = |hit;

endmodule

// File: rtl/wdog_stage_ctr.sv
module wdog_stage_ctr
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             go_i,
  input  logic             halt_i,
  input  logic             tick_i,
  input  wd_cfg_t          cfg_i,
  output logic             running_o,
  output logic [STG_W-1:0] stage_o,
  output logic             loc_irq_o,
  output logic             fast_irq_o,
  output logic             rmt_irq_o,
  output logic             dbg_rst_o,
  output logic             por_rst_o
);

  logic [PER_W-1:0] pcnt;
  logic [PER_W:0]   per_eff;
  logic [PER_W:0]   pcnt_inc;
  logic             count_en;
  logic             grp_done;
  logic [STG_W-1:0] stage_nx;
  logic             mid_stage;

  assign per_eff   = (cfg_i.period == '0) ? (PER_W+1)'(1) : {1'b0, cfg_i.period};
  assign pcnt_inc  = {1'b0, pcnt} + (PER_W+1)'(1);
  assign count_en  = tick_i && running_o;
  assign grp_done  = count_en && (pcnt_inc >= per_eff);
  assign stage_nx  = (stage_o == STG_W'(LAST_STAGE)) ? stage_o : stage_o + STG_W'(1);
  assign mid_stage = (stage_nx >= STG_W'(2)) && (stage_nx <= STG_W'(LAST_STAGE - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      running_o  <= 1'b0;
      pcnt       <= '0;
      stage_o    <= '0;
      loc_irq_o  <= 1'b0;
      fast_irq_o <= 1'b0;
      rmt_irq_o  <= 1'b0;
      dbg_rst_o  <= 1'b0;
      por_rst_o  <= 1'b0;
    end else if (halt_i || go_i) begin
      running_o  <= go_i;
      pcnt       <= '0;
      stage_o    <= '0;
      loc_irq_o  <= 1'b0;
      fast_irq_o <= 1'b0;
      rmt_irq_o  <= 1'b0;
    end else if (grp_done) begin
      pcnt    <= '0;
      stage_o <= stage_nx;
      if (stage_nx == STG_W'(1)) begin
        loc_irq_o <= loc_irq_o | cfg_i.loc_en;
      end
      if (mid_stage) begin
        fast_irq_o <= fast_irq_o | cfg_i.fast_en;
        rmt_irq_o  <= rmt_irq_o | cfg_i.rmt_en;
      end
      if (stage_nx == STG_W'(LAST_STAGE)) begin
        dbg_rst_o <= dbg_rst_o | cfg_i.dbg_en;
        por_rst_o <= por_rst_o | cfg_i.por_en;
      end
    end else if (count_en) begin
      pcnt <= pcnt_inc[PER_W-1:0];
    end
  end

endmodule

// File: rtl/stage_wdog.sv
module stage_wdog
  import wdog_pkg::*;
#(
  parameter int N_TMR  = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [N_TMR-1:0]  exp_i,
  output logic              irq_local_o,
  output logic              irq_fast_o,
  output logic              irq_remote_o,
  output logic              rst_debug_o,
  output logic              rst_por_o
);

  wd_cfg_t          cfg;
  logic             locked, armed, go, halt, tick, running;
  logic [STG_W-1:0] stage;

  wdog_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .cfg_o(cfg), .locked_o(locked), .armed_o(armed),
    .go_o(go), .halt_o(halt)
  );

  wdog_tick_sel #(.N_TMR(N_TMR)) u_sel (
    .exp_i(exp_i), .sel_i(cfg.src), .tick_o(tick)
  );

  wdog_stage_ctr u_stage (
    .clk(clk), .rst(rst),
    .go_i(go), .halt_i(halt), .tick_i(tick), .cfg_i(cfg),
    .running_o(running), .stage_o(stage),
    .loc_irq_o(irq_local_o), .fast_irq_o(irq_fast_o), .rmt_irq_o(irq_remote_o),
    .dbg_rst_o(rst_debug_o), .por_rst_o(rst_por_o)
  );

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CFG_W-1:0]  cfg,
  input logic              locked,
  input logic              armed,
  input logic              go,
  input logic              running,
  input logic [STG_W-1:0]  stage,
  input logic              irq_local_o,
  input logic              irq_fast_o,
  input logic              irq_remote_o,
  input logic              rst_debug_o,
  input logic              rst_por_o
);

  p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    (locked && wr_en && wr_addr == ADDR_W'(OFS_CFG)) |=> $stable(cfg));

  p_go_clears_r4: assert property (@(posedge clk) disable iff (rst)
    go |=> (running && stage == '0 && !irq_local_o && !irq_fast_o && !irq_remote_o));

  p_stage_bound_r5: assert property (@(posedge clk) disable iff (rst)
    stage <= STG_W'(LAST_STAGE));

  p_local_at_first_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_local_o) |-> (stage == STG_W'(1)));

  p_por_at_last_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_por_o) |-> (stage == STG_W'(LAST_STAGE)));

  p_por_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    rst_por_o |=> rst_por_o);

  p_dbg_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    rst_debug_o |=> rst_debug_o);

  p_stop_needs_key_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> $past(armed));

endmodule

bind stage_wdog wdog_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .cfg(cfg), .locked(locked), .armed(armed), .go(go),
  .running(running), .stage(stage),
  .irq_local_o(irq_local_o), .irq_fast_o(irq_fast_o), .irq_remote_o(irq_remote_o),
  .rst_debug_o(rst_debug_o), .rst_por_o(rst_por_o)
);

// File: tb/tb_stage_wdog.sv
module tb_stage_wdog;
  localparam int N  = 6;
  localparam int AW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [N-1:0]  exp_i = '0;
  logic          irq_local_o, irq_fast_o, irq_remote_o, rst_debug_o, rst_por_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  stage_wdog #(.N_TMR(N), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .exp_i(exp_i),
    .irq_local_o(irq_local_o), .irq_fast_o(irq_fast_o), .irq_remote_o(irq_remote_o),
    .rst_debug_o(rst_debug_o), .rst_por_o(rst_por_o)
  );

  // behavioural reference model
  int unsigned m_cfg, m_rd;
  bit m_armed, m_run, m_loc, m_fast, m_rmt, m_dbg, m_por;
  int m_pc, m_stage;

  always @(posedge clk) begin
    if (rst) begin
      m_cfg = 0; m_rd = 0; m_armed = 0; m_run = 0; m_pc = 0; m_stage = 0;
      m_loc = 0; m_fast = 0; m_rmt = 0; m_dbg = 0; m_por = 0;
    end else begin
      int unsigned old_cfg;
      int src, per;
      bit stop, start, tick;
      old_cfg = m_cfg;
      m_rd = (rd_en && rd_addr == 4'h0) ? old_cfg : 0;
      stop = 0; start = 0;
      if (wr_en && wr_addr == 4'h0 && !old_cfg[12]) m_cfg = wr_data & 32'h1FFFF;
      if (wr_en && wr_addr == 4'hC) m_armed = (wr_data == 32'h0000C45A);
      if (wr_en && wr_addr == 4'h8) begin
        stop = wr_data[1] && m_armed;
        start = wr_data[0] && !stop;
        m_armed = 0;
      end
      src = old_cfg & 32'hF;
      per = (old_cfg >> 4) & 32'hFF;
      if (per == 0) per = 1;
      tick = m_run && src < N && exp_i[src];
      if (stop || start) begin
        m_run = start; m_pc = 0; m_stage = 0; m_loc = 0; m_fast = 0; m_rmt = 0;
      end else if (tick) begin
        if (m_pc + 1 >= per) begin
          m_pc = 0;
          if (m_stage < 5) m_stage++;
          if (m_stage == 1) m_loc |= old_cfg[12];
          if (m_stage >= 2 && m_stage <= 4) begin
            m_fast |= old_cfg[13]; m_rmt |= old_cfg[14];
          end
          if (m_stage == 5) begin
            m_dbg |= old_cfg[15]; m_por |= old_cfg[16];
          end
        end else m_pc++;
      end
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model (R10: same-edge timing)
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R6/R10", "irq_local_o", irq_local_o, m_loc);
      chk("R6/R10", "irq_fast_o", irq_fast_o, m_fast);
      chk("R6/R10", "irq_remote_o", irq_remote_o, m_rmt);
      chk("R7/R10", "rst_debug_o", rst_debug_o, m_dbg);
      chk("R7/R10", "rst_por_o", rst_por_o, m_por);
      chk("R2", "rd_data", rd_data, m_rd);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rd_data;
  endtask

  task automatic pulse(input int idx, input int cnt);
    for (int k = 0; k < cnt; k++) begin
      exp_i = '0; exp_i[idx] = 1'b1;
      @(negedge clk);
      exp_i = '0;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog timeout act=running exp=done");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1", "outputs", {irq_local_o, irq_fast_o, irq_remote_o, rst_debug_o, rst_por_o}, 0);
    rd(4'h0, v); chk("R1", "cfg after reset", v, 0);
    // R2
    wr(4'h0, 32'h0001E032);
    rd(4'h0, v); chk("R2", "cfg readback", v, 32'h0001E032);
    rd(4'h4, v); chk("R2", "unmapped read", v, 0);
    // R5: not running yet
    pulse(2, 3); chk("R5", "stopped ignores pulses", irq_fast_o, 0);
    wr(4'h8, 32'h1);
    pulse(1, 6); chk("R5", "other source ignored", irq_fast_o, 0);
    pulse(2, 3); chk("R6", "local disabled stays low", irq_local_o, 0);
    pulse(2, 2); chk("R5", "partial group", irq_fast_o, 0);
    pulse(2, 1); chk("R6", "fast at stage 2", irq_fast_o, 1);
    chk("R6", "remote at stage 2", irq_remote_o, 1);
    pulse(2, 6); chk("R7", "no por at stage 4", rst_por_o, 0);
    pulse(2, 3); chk("R7", "por at stage 5", rst_por_o, 1);
    chk("R7", "debug at stage 5", rst_debug_o, 1);
    pulse(2, 9); chk("R7", "saturated por", rst_por_o, 1);
    // R4
    wr(4'h8, 32'h1);
    chk("R4", "start clears fast", irq_fast_o, 0);
    chk("R4", "start keeps por", rst_por_o, 1);
    // R8
    wr(4'h8, 32'h2);
    pulse(2, 6); chk("R8", "disable without key ignored", irq_fast_o, 1);
    wr(4'hC, 32'h0000C45A); wr(4'hC, 32'h00001234); wr(4'h8, 32'h2);
    wr(4'h8, 32'h1);
    pulse(2, 6); chk("R8", "wrong key disarms", irq_fast_o, 1);
    wr(4'hC, 32'h0000C45A); wr(4'h8, 32'h1); wr(4'h8, 32'h2);
    pulse(2, 6); chk("R8", "key consumed by command", irq_fast_o, 1);
    // R9
    wr(4'hC, 32'h0000C45A); wr(4'h8, 32'h3);
    chk("R9", "disable clears fast", irq_fast_o, 0);
    pulse(2, 6); chk("R9", "stopped after disable", irq_fast_o, 0);
    // R5 out-of-range source, period 0
    wr(4'h0, 32'h00002007); wr(4'h8, 32'h1);
    for (int i = 0; i < N; i++) pulse(i, 2);
    chk("R5", "source beyond timers", irq_fast_o, 0);
    wr(4'h0, 32'h00002005);
    pulse(5, 1); chk("R5", "period 0 as 1, stage 1", irq_fast_o, 0);
    pulse(5, 1); chk("R5", "period 0 as 1, stage 2", irq_fast_o, 1);
    // R3 lock
    wr(4'h0, 32'h00001010);
    rd(4'h0, v); chk("R3", "locked value", v, 32'h00001010);
    wr(4'h0, 32'h00002005);
    rd(4'h0, v); chk("R3", "write ignored while locked", v, 32'h00001010);
    wr(4'h8, 32'h1);
    pulse(0, 1); chk("R6", "local at stage 1", irq_local_o, 1);
    chk("R7", "por held to the end", rst_por_o, 1);
    wr(4'hC, 32'h0000C45A); wr(4'h8, 32'h2);
    chk("R9", "disable clears local", irq_local_o, 0);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule